// File: doc/BRIEF.md
# Per-Pin Interrupt GPIO Port

This block is a single general-purpose I/O port of up to eight pins, reached through a simple synchronous register bus. Each pin has its own 32-byte register window. The window holds the pin's enable, direction, trigger settings, debounce threshold, output level, output float control, a readback of the filtered input and an interrupt clear. Pad drive is presented as separate data and output-enable vectors, so a pad ring can build the tri-state buffers.

Every pad input goes through a two-flop synchronizer and then a debounce filter with a programmable threshold. The filtered level feeds an event detector. Each pin can be set to fire on a level, on a single edge or on both edges, and a polarity bit selects high or rising versus low or falling. An event sets a sticky pending bit, but only while the pin, its trigger and its interrupt enable are all active. Software reads the pending bits of all pins from one status word and clears them pin by pin. One interrupt line is the OR of all pending bits.

Top module: `gpio_port_irq`

## Requirements
- R1: Pin n owns byte addresses n*0x20 to n*0x20+0x1F, with these offsets: 0x00 configuration, 0x04 debounce threshold, 0x08 input, 0x0C output float, 0x10 output level, 0x14 interrupt clear. The configuration word reads back with only bits 0, 1, 2, 3, 4 and 6 kept and the other bits zero. The threshold word reads back with only bits [7:0] kept. A read returns its data on bus_rdata in the cycle after bus_rd is sampled.
- R2: The configuration bits are: bit 0 pin enable, bit 1 output direction, bits [3:2] trigger mode, bit 4 polarity, bit 6 interrupt enable. pad_oe[n] is high exactly when pin n is enabled, set to output and its float bit (bit 0 at 0x0C) is clear. pad_out[n] follows bit 0 at 0x10.
- R3: Bit 0 of the input register is the pad level after a two-flop synchronizer and the debounce filter.
- R4: A new synchronized level is accepted only after it has been stable for threshold+1 clock cycles. A threshold of 0 accepts a level after one cycle, so a one-cycle pulse passes. A pulse shorter than threshold+1 cycles changes neither the input register nor the pending bit.
- R5: Trigger mode 2 (single edge) sets the pending bit on a rising filtered edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge does not set it.
- R6: Trigger mode 3 (both edges) sets the pending bit on every filtered edge, whatever the polarity.
- R7: Trigger mode 1 (level) sets the pending bit while the filtered level equals the polarity bit. A clear while the level is still active leaves the bit set.
- R8: An event does not set the pending bit when the pin enable is 0, the interrupt enable is 0 or the trigger mode is 0.
- R9: A pending bit stays set until software writes a word with bit 0 = 1 to that pin's clear register. A write of 0 to the clear register has no effect.
- R10: The status word at address 0x104 carries pin n's pending bit in bit n. irq_out is high whenever any pending bit is set.
- R11: After reset, every configuration and threshold register is 0, every float bit is 1, every output level is 0, no bit is pending and no pad is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | NPINS (8) | Asynchronous pad levels |
| pad_out | output | NPINS (8) | Driven pad levels |
| pad_oe | output | NPINS (8) | Pad output enables |
| irq_out | output | 1 | OR of all pending bits |

## Verification
The assertions assume that a bus write and a read never address the same register in one cycle. They also assume that pad inputs are sampled only through the synchronizer, so any pad change is legal in any cycle. The bench drives pads and bus strobes on the falling edge only. It holds each random pad pattern for several cycles with the threshold at zero, so the filtered level settles before the status word is read. The debounce windows are exercised only in directed pulse tests whose widths sit exactly at and one below the threshold+1 limit.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int BUS_W = 32;

    localparam logic [4:0] OFS_CFG  = 5'h00;
    localparam logic [4:0] OFS_DEB  = 5'h04;
    localparam logic [4:0] OFS_IN   = 5'h08;
    localparam logic [4:0] OFS_OCTL = 5'h0C;
    localparam logic [4:0] OFS_OVAL = 5'h10;
    localparam logic [4:0] OFS_CLR  = 5'h14;
    localparam int unsigned STAT_OFS = 32'h104;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic       irq_en;
        logic       pol;
        trig_mode_e mode;
        logic       dir_out;
        logic       pin_en;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_unpack(input logic [BUS_W-1:0] w);
        pin_cfg_t c;
        c.pin_en  = w[0];
        c.dir_out = w[1];
        c.mode    = trig_mode_e'(w[3:2]);
        c.pol     = w[4];
        c.irq_en  = w[6];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_pack(input pin_cfg_t c);
        logic [BUS_W-1:0] w;
        w      = '0;
        w[0]   = c.pin_en;
        w[1]   = c.dir_out;
        w[3:2] = c.mode;
        w[4]   = c.pol;
        w[6]   = c.irq_en;
        return w;
    endfunction

    function automatic logic trig_hit(input trig_mode_e m, input logic pol,
                                      input logic cur, input logic prev);
        logic hit;
        case (m)
            TRIG_LEVEL: hit = (cur == pol);
            TRIG_EDGE:  hit = pol ? (cur & ~prev) : (~cur & prev);
            TRIG_BOTH:  hit = (cur ^ prev);
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pad_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             sync_o,
    output logic             filt_o
);
    logic             s1_q, s2_q, filt_q;
    logic [THR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            s1_q <= pad_i;
            s2_q <= s1_q;
            if (s2_q == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == thr_i) begin
                filt_q <= s2_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sync_o = s2_q;
    assign filt_o = filt_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg_i,
    input  logic     lvl_i,
    input  logic     clr_i,
    output logic     pend_o
);
    logic prev_q, pend_q, fire;

    assign fire = cfg_i.pin_en & cfg_i.irq_en &
                  trig_hit(cfg_i.mode, cfg_i.pol, lvl_i, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            if (fire)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_out
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

    pin_cfg_t         cfg_q [NPINS];
    logic [THR_W-1:0] thr_q [NPINS];
    logic [NPINS-1:0] float_q, oval_q;
    logic [NPINS-1:0] clr_v, sync_v, filt_v, pend_v, arm_v;
    logic [BUS_W-1:0] rd_val, rdata_q;

    logic       in_win;
    logic [2:0] pin_sel;
    logic [4:0] reg_sel;

    assign in_win  = (bus_addr[ADDR_W-1:8] == HI_W'(0));
    assign pin_sel = bus_addr[7:5];
    assign reg_sel = bus_addr[4:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPINS; i++) begin
                cfg_q[i] <= '0;
                thr_q[i] <= '0;
            end
            float_q <= '1;
            oval_q  <= '0;
        end else if (bus_wr && in_win) begin
            for (int i = 0; i < NPINS; i++) begin
                if (pin_sel == 3'(i)) begin
                    case (reg_sel)
                        OFS_CFG:  cfg_q[i]   <= cfg_unpack(bus_wdata);
                        OFS_DEB:  thr_q[i]   <= bus_wdata[THR_W-1:0];
                        OFS_OCTL: float_q[i] <= bus_wdata[0];
                        OFS_OVAL: oval_q[i]  <= bus_wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NPINS; i++)
            clr_v[i] = bus_wr & in_win & (pin_sel == 3'(i)) &
                       (reg_sel == OFS_CLR) & bus_wdata[0];
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gpio_in_filter #(.THR_W(THR_W)) u_flt (
            .clk    (clk),
            .rst    (rst),
            .pad_i  (pad_in[g]),
            .thr_i  (thr_q[g]),
            .sync_o (sync_v[g]),
            .filt_o (filt_v[g])
        );
        gpio_evt_detect u_evt (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (cfg_q[g]),
            .lvl_i  (filt_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend_v[g])
        );
        assign pad_oe[g] = cfg_q[g].pin_en & cfg_q[g].dir_out & ~float_q[g];
        assign arm_v[g]  = cfg_q[g].pin_en & cfg_q[g].irq_en &
                           (cfg_q[g].mode != TRIG_OFF);
    end

    assign pad_out = oval_q;
    assign irq_out = |pend_v;

    always_comb begin
        rd_val = '0;
        if (bus_addr == STAT_ADDR) begin
            rd_val = BUS_W'(pend_v);
        end else if (in_win) begin
            for (int i = 0; i < NPINS; i++) begin
                if (pin_sel == 3'(i)) begin
                    case (reg_sel)
                        OFS_CFG:  rd_val = cfg_pack(cfg_q[i]);
                        OFS_DEB:  rd_val = BUS_W'(thr_q[i]);
                        OFS_IN:   rd_val = BUS_W'(filt_v[i]);
                        OFS_OCTL: rd_val = BUS_W'(float_q[i]);
                        OFS_OVAL: rd_val = BUS_W'(oval_q[i]);
                        default:  rd_val = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_val;
    end

    assign bus_rdata = rdata_q;
endmodule

module gpio_port_irq_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] pend_v,
    input logic [NPINS-1:0] clr_v,
    input logic [NPINS-1:0] arm_v,
    input logic [NPINS-1:0] sync_v,
    input logic [NPINS-1:0] filt_v,
    input logic [NPINS-1:0] float_q,
    input logic [NPINS-1:0] pad_oe
);
    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R9: a pending bit survives every cycle without a clear
        a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
            (pend_v[g] && !clr_v[g]) |=> pend_v[g]);
        // R8: a disarmed pin never raises its pending bit
        a_r8_gated: assert property (@(posedge clk) disable iff (rst)
            (!arm_v[g] && !pend_v[g]) |=> !pend_v[g]);
        // R4: the filtered level only ever takes the synchronized sample
        a_r4_filter_src: assert property (@(posedge clk) disable iff (rst)
            (filt_v[g] != $past(filt_v[g])) |-> (filt_v[g] == $past(sync_v[g])));
        // R2: a floated pin is never driven
        a_r2_float_off: assert property (@(posedge clk) disable iff (rst)
            float_q[g] |-> !pad_oe[g]);
    end
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pend_v  (pend_v),
    .clr_v   (clr_v),
    .arm_v   (arm_v),
    .sync_v  (sync_v),
    .filt_v  (filt_v),
    .float_q (float_q),
    .pad_oe  (pad_oe)
);

// File: tb/gpio_port_irq_test.sv
module gpio_port_irq_test;
    localparam int CLK_P = 10;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic        irq_out;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_port_irq uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [11:0] reg_at(input int pin, input logic [4:0] ofs);
        return 12'(pin * 32) + 12'(ofs);
    endfunction

    function automatic logic cfg_word(input bit en, input bit dir, input int mode,
                                      input bit pol, input bit ie, output logic [31:0] w);
        w = {25'd0, ie, 1'b0, pol, 2'(mode), dir, en};
        return 1'b1;
    endfunction

    // expected pending bit after a settled change from old to new level
    function automatic logic exp_pend(input logic [31:0] c, input logic o, input logic n);
        logic pol;
        pol = c[4];
        if (!(c[0] && c[6] && c[3:2] != 2'd0)) return 1'b0;
        case (c[3:2])
            2'd1: return (o == pol) || (n == pol);
            2'd2: return pol ? (!o && n) : (o && !n);
            default: return o != n;
        endcase
    endfunction

    task automatic clear_all();
        for (int p = 0; p < NP; p++) wr(reg_at(p, 5'h14), 32'h1);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, w, cfgs [NP];
        logic [NP-1:0] oldp, newp, expv;
        void'($urandom(32'h5eed_0107));
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R11 reset state
        rd(12'h104, d);     check(d == 0, "R11 status", d, 0);
        check(irq_out == 0, "R11 irq", 32'(irq_out), 0);
        check(pad_oe == 0, "R11 oe", 32'(pad_oe), 0);
        rd(reg_at(0, 5'h00), d); check(d == 0, "R11 cfg", d, 0);
        rd(reg_at(3, 5'h0C), d); check(d == 1, "R11 float", d, 1);

        // R1 readback masks
        wr(reg_at(2, 5'h00), 32'hFFFF_FFFF);
        rd(reg_at(2, 5'h00), d); check(d == 32'h5F, "R1 cfg mask", d, 32'h5F);
        wr(reg_at(2, 5'h04), 32'h0000_01AB);
        rd(reg_at(2, 5'h04), d); check(d == 32'hAB, "R1 thr mask", d, 32'hAB);
        wr(reg_at(2, 5'h00), 0); wr(reg_at(2, 5'h04), 0);
        rd(reg_at(1, 5'h00), d); check(d == 0, "R1 other pin", d, 0);

        // R2 pad drive
        wr(reg_at(1, 5'h10), 1); wr(reg_at(1, 5'h0C), 0);
        void'(cfg_word(1, 1, 0, 0, 0, w)); wr(reg_at(1, 5'h00), w);
        cyc(1);
        check(pad_oe == 8'h02, "R2 oe on", 32'(pad_oe), 2);
        check(pad_out[1] == 1, "R2 out level", 32'(pad_out), 2);
        wr(reg_at(1, 5'h0C), 1); cyc(1);
        check(pad_oe == 0, "R2 float", 32'(pad_oe), 0);
        wr(reg_at(1, 5'h0C), 0); wr(reg_at(1, 5'h00), 1); cyc(1);
        check(pad_oe == 0, "R2 input dir", 32'(pad_oe), 0);
        wr(reg_at(1, 5'h00), 0);

        // R3 input readback
        pad_in[4] = 1'b1; cyc(5);
        rd(reg_at(4, 5'h08), d); check(d == 1, "R3 input high", d, 1);
        pad_in[4] = 1'b0; cyc(5);
        rd(reg_at(4, 5'h08), d); check(d == 0, "R3 input low", d, 0);

        // R5 single edge, rising
        void'(cfg_word(1, 0, 2, 1, 1, w)); wr(reg_at(0, 5'h00), w);
        pad_in[0] = 1'b1; cyc(6);
        rd(12'h104, d); check(d == 1, "R5 rise hit", d, 1);
        check(irq_out == 1, "R10 irq set", 32'(irq_out), 1);
        // R9 write of zero does not clear
        wr(reg_at(0, 5'h14), 0);
        rd(12'h104, d); check(d == 1, "R9 zero write", d, 1);
        wr(reg_at(0, 5'h14), 1);
        rd(12'h104, d); check(d == 0, "R9 clear", d, 0);
        pad_in[0] = 1'b0; cyc(6);
        rd(12'h104, d); check(d == 0, "R5 fall ignored", d, 0);
        // R5 falling polarity
        void'(cfg_word(1, 0, 2, 0, 1, w)); wr(reg_at(0, 5'h00), w);
        pad_in[0] = 1'b1; cyc(6);
        rd(12'h104, d); check(d == 0, "R5 rise ignored", d, 0);
        pad_in[0] = 1'b0; cyc(6);
        rd(12'h104, d); check(d == 1, "R5 fall hit", d, 1);
        wr(reg_at(0, 5'h14), 1);

        // R6 both edges, both polarities
        for (int pl = 0; pl < 2; pl++) begin
            void'(cfg_word(1, 0, 3, pl[0], 1, w)); wr(reg_at(0, 5'h00), w);
            pad_in[0] = 1'b1; cyc(6);
            rd(12'h104, d); check(d == 1, "R6 rise", d, 1);
            wr(reg_at(0, 5'h14), 1);
            pad_in[0] = 1'b0; cyc(6);
            rd(12'h104, d); check(d == 1, "R6 fall", d, 1);
            wr(reg_at(0, 5'h14), 1);
        end

        // R7 level high
        void'(cfg_word(1, 0, 1, 1, 1, w)); wr(reg_at(0, 5'h00), w);
        rd(12'h104, d); check(d == 0, "R7 inactive", d, 0);
        pad_in[0] = 1'b1; cyc(6);
        wr(reg_at(0, 5'h14), 1);
        rd(12'h104, d); check(d == 1, "R7 held while active", d, 1);
        pad_in[0] = 1'b0; cyc(6);
        wr(reg_at(0, 5'h14), 1);
        rd(12'h104, d); check(d == 0, "R7 cleared after", d, 0);

        // R8 gating
        void'(cfg_word(1, 0, 3, 0, 0, w)); wr(reg_at(0, 5'h00), w);
        pad_in[0] = 1'b1; cyc(6);
        rd(12'h104, d); check(d == 0, "R8 irq enable off", d, 0);
        void'(cfg_word(0, 0, 3, 0, 1, w)); wr(reg_at(0, 5'h00), w);
        pad_in[0] = 1'b0; cyc(6);
        rd(12'h104, d); check(d == 0, "R8 pin off", d, 0);
        void'(cfg_word(1, 0, 0, 1, 1, w)); wr(reg_at(0, 5'h00), w);
        pad_in[0] = 1'b1; cyc(6);
        rd(12'h104, d); check(d == 0, "R8 mode none", d, 0);
        pad_in[0] = 1'b0; cyc(6);
        wr(reg_at(0, 5'h00), 0);

        // R10 bit positions and OR
        void'(cfg_word(1, 0, 3, 0, 1, w));
        wr(reg_at(3, 5'h00), w); wr(reg_at(7, 5'h00), w);
        pad_in[3] = 1'b1; pad_in[7] = 1'b1; cyc(6);
        rd(12'h104, d); check(d == 32'h88, "R10 map", d, 32'h88);
        wr(reg_at(3, 5'h14), 1); cyc(1);
        check(irq_out == 1, "R10 irq one left", 32'(irq_out), 1);
        wr(reg_at(7, 5'h14), 1); cyc(1);
        check(irq_out == 0, "R10 irq none", 32'(irq_out), 0);
        wr(reg_at(3, 5'h00), 0); wr(reg_at(7, 5'h00), 0);
        pad_in[3] = 1'b0; pad_in[7] = 1'b0; cyc(6);

        // R4 debounce
        void'(cfg_word(1, 0, 3, 0, 1, w)); wr(reg_at(5, 5'h00), w);
        wr(reg_at(5, 5'h04), 3);
        @(negedge clk); pad_in[5] = 1'b1; cyc(3); pad_in[5] = 1'b0; cyc(10);
        rd(12'h104, d); check(d == 0, "R4 short pulse", d, 0);
        rd(reg_at(5, 5'h08), d); check(d == 0, "R4 input unchanged", d, 0);
        @(negedge clk); pad_in[5] = 1'b1; cyc(4); pad_in[5] = 1'b0; cyc(12);
        rd(12'h104, d); check(d == 32'h20, "R4 at limit", d, 32'h20);
        wr(reg_at(5, 5'h14), 1);
        wr(reg_at(5, 5'h04), 0);
        @(negedge clk); pad_in[5] = 1'b1; cyc(1); pad_in[5] = 1'b0; cyc(8);
        rd(12'h104, d); check(d == 32'h20, "R4 zero threshold", d, 32'h20);
        wr(reg_at(5, 5'h00), 0); wr(reg_at(5, 5'h14), 1);

        // random configurations and pad patterns (R5 R6 R7 R8 R10)
        oldp = pad_in;
        for (int it = 0; it < 40; it++) begin
            for (int p = 0; p < NP; p++) begin
                void'(cfg_word(1'($urandom % 4 != 0), 0, int'($urandom % 4),
                               1'($urandom), 1'($urandom % 4 != 0), cfgs[p]));
                wr(reg_at(p, 5'h00), cfgs[p]);
            end
            clear_all(); cyc(4);
            for (int p = 0; p < NP; p++) expv[p] = exp_pend(cfgs[p], oldp[p], oldp[p]);
            rd(12'h104, d); check(d == 32'(expv), "R7 random settled", d, 32'(expv));
            newp = 8'($urandom);
            pad_in = newp; cyc(8);
            for (int p = 0; p < NP; p++) expv[p] = exp_pend(cfgs[p], oldp[p], newp[p]);
            rd(12'h104, d); check(d == 32'(expv), "R10 random status", d, 32'(expv));
            check(irq_out == (expv != 0), "R10 random irq", 32'(irq_out), 32'(expv != 0));
            oldp = newp;
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule